// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block keeps the status byte of a serial memory and decides, one instruction at a time, whether a request to rewrite that byte may go ahead. A front end that has already decoded the serial traffic gives it a one-cycle pulse when a write-enable instruction completes. It also gives a one-cycle pulse, together with the data byte, when a status-write instruction completes. A separate input reports that a memory-array write is in progress.

A status write that is allowed is timed by an internal counter that stands in for the nonvolatile cell delay. The new value becomes visible when that counter runs out. The protection scheme combines a write-protect pin with a protect-enable bit. If that bit is set while the pin is low, the register stays locked until the pin changes level. This gives a one-time lock that only a change at board level can release.

Top module: `srwp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, `blk_lock_o` is 0 and `sr_write_ok_o` is low.
- R2: A write-enable pulse sets the enable latch, which reads as status bit 1. The pulse is ignored while the write-in-progress bit (status bit 0) is high.
- R3: A status-write pulse is accepted only when the enable latch is set, no write is in progress and the register is not protected. An accepted write raises `sr_write_ok_o` for exactly one cycle, in the cycle after the pulse. A rejected write changes nothing, including the enable latch.
- R4: When the protect-enable bit (status bit 7) is 0, the pin level has no effect on whether a status write is accepted.
- R5: When the protect-enable bit is 1 and the pin is high, status writes are accepted as normal.
- R6: When the protect-enable bit becomes 1 while the pin is low, the register is locked. Status writes are then rejected until the pin has gone high.
- R7: Pulling the pin low during a status write that has already been accepted does not stop that write from completing. When the protect-enable bit is 1, every later status write is rejected while the pin stays low.
- R8: Only data bits 7 and 3:2 of a status write are stored. Data bits 1:0 and 6:4 are discarded, and status bits 6:4 always read 0.
- R9: The write-in-progress bit reads 1 for `SR_WRITE_CYCLES` cycles after an accepted status write and whenever `array_busy_i` is high. During that time the status byte stays readable and shows the old stored bits. The new bits appear once the cycle ends.
- R10: The enable latch clears when a status write cycle ends and when `array_busy_i` falls.
- R11: `blk_lock_o` always equals status bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wp_pin_i | input | 1 | Write-protect pin, asynchronous, low protects |
| wren_pulse_i | input | 1 | Write-enable instruction completed |
| wrsr_pulse_i | input | 1 | Status-write instruction completed |
| wrsr_data_i | input | 8 | Data byte of the status write |
| array_busy_i | input | 1 | Memory-array nonvolatile write in progress |
| status_o | output | 8 | Status byte as read back |
| sr_write_ok_o | output | 1 | One-cycle strobe for an accepted status write |
| blk_lock_o | output | 2 | Block-lock field |

## Verification
On every cycle, the embedded properties check four things. An accepted write always had the enable latch set and was not protected. The strobe lasts one cycle, and the write-in-progress bit follows it. The latch is clear after a write cycle ends, and a lock is released only after a pin edge. Other behaviour needs whole sequences and only the bench's scenarios can show it. These are the lock being entered by the write that sets protect-enable while the pin is low, a write that finishes after the pin drops during it, bits being discarded, and old values staying visible during the busy window.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    localparam int unsigned STAT_W = 8;

    // bit positions that the read-back format depends on
    localparam int unsigned BIT_WIP  = 0;
    localparam int unsigned BIT_WEL  = 1;
    localparam int unsigned BIT_BL_L = 2;
    localparam int unsigned BIT_BL_H = 3;
    localparam int unsigned BIT_PEN  = 7;
    localparam int unsigned BL_W     = BIT_BL_H - BIT_BL_L + 1;

    typedef struct packed {
        logic            wel;        // enable latch
        logic            pen;        // protect-enable (stored)
        logic [BL_W-1:0] bl;         // block-lock field (stored)
        logic            locked;     // lock flag, released by pin edge
        logic            pend_pen;   // value waiting for commit
        logic [BL_W-1:0] pend_bl;
        logic            ok;         // accepted-write strobe
        logic            arr_prev;   // previous array-busy level
    } ctrl_state_t;

endpackage

// File: rtl/srwp_pin_sync.sv
module srwp_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o,
    output logic edge_o
);

    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = pin_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
        end
    endgenerate

    always_comb begin
        prev_d = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign pin_o  = chain_q[STAGES-1];
    assign edge_o = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/srwp_nv_timer.sv
module srwp_nv_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int unsigned CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CNT_W'(1));

    AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R9

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o); // R9

endmodule

// File: rtl/srwp_ctrl.sv
module srwp_ctrl
    import srwp_pkg::*;
#(
    parameter int unsigned SR_WRITE_CYCLES = 16,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin_i,
    input  logic              wren_pulse_i,
    input  logic              wrsr_pulse_i,
    input  logic [STAT_W-1:0] wrsr_data_i,
    input  logic              array_busy_i,
    output logic [STAT_W-1:0] status_o,
    output logic              sr_write_ok_o,
    output logic [BL_W-1:0]   blk_lock_o
);

    ctrl_state_t st_d, st_q;

    logic pin_s, pin_edge;
    logic tmr_busy, tmr_done;
    logic wip, blocked, accept, lock_set, arr_fell, nv_done;

    srwp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (wp_pin_i),
        .pin_o  (pin_s),
        .edge_o (pin_edge)
    );

    srwp_nv_timer #(.CYCLES(SR_WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    always_comb begin
        wip      = tmr_busy | array_busy_i;
        lock_set = st_q.pen & ~pin_s;
        blocked  = st_q.pen & (st_q.locked | ~pin_s);
        accept   = wrsr_pulse_i & st_q.wel & ~wip & ~blocked;
        arr_fell = st_q.arr_prev & ~array_busy_i;
        nv_done  = tmr_done | arr_fell;

        st_d          = st_q;
        st_d.ok       = accept;
        st_d.arr_prev = array_busy_i;

        // lock flag: a pin edge re-evaluates, otherwise it only sets
        if (pin_edge) st_d.locked = lock_set;
        else          st_d.locked = st_q.locked | lock_set;

        if (wren_pulse_i && !wip) st_d.wel = 1'b1;
        if (nv_done)              st_d.wel = 1'b0;

        if (accept) begin
            st_d.pend_pen = wrsr_data_i[BIT_PEN];
            st_d.pend_bl  = wrsr_data_i[BIT_BL_H:BIT_BL_L];
        end

        if (tmr_done) begin
            st_d.pen = st_q.pend_pen;
            st_d.bl  = st_q.pend_bl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o           = '0;
        status_o[BIT_WIP]  = wip;
        status_o[BIT_WEL]  = st_q.wel;
        status_o[BIT_BL_H:BIT_BL_L] = st_q.bl;
        status_o[BIT_PEN]  = st_q.pen;
    end

    assign sr_write_ok_o = st_q.ok;
    assign blk_lock_o    = st_q.bl;

    AST_OK_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        sr_write_ok_o |-> $past(st_q.wel)); // R3

    AST_OK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_write_ok_o |=> !sr_write_ok_o); // R3

    AST_OK_NOT_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        sr_write_ok_o |-> !$past(blocked)); // R6

    AST_WIP_WITH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        sr_write_ok_o |-> status_o[BIT_WIP]); // R9

    AST_WEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmr_done) |-> !st_q.wel); // R10

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.locked) |-> $past(pin_edge)); // R6

endmodule

// File: tb/sim_srwp_ctrl.sv
`timescale 1ns/1ps
module sim_srwp_ctrl;

    localparam int unsigned N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_pin_i = 1'b1;
    logic       wren_pulse_i = 1'b0;
    logic       wrsr_pulse_i = 1'b0;
    logic [7:0] wrsr_data_i = 8'h00;
    logic       array_busy_i = 1'b0;
    logic [7:0] status_o;
    logic       sr_write_ok_o;
    logic [1:0] blk_lock_o;

    always #2 clk = ~clk;

    srwp_ctrl #(.SR_WRITE_CYCLES(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wp_pin_i(wp_pin_i),
        .wren_pulse_i(wren_pulse_i), .wrsr_pulse_i(wrsr_pulse_i),
        .wrsr_data_i(wrsr_data_i), .array_busy_i(array_busy_i),
        .status_o(status_o), .sr_write_ok_o(sr_write_ok_o),
        .blk_lock_o(blk_lock_o)
    );

    typedef struct {
        logic [7:0] stat;
        int         oks;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   ok_count = 0;
    bit   done     = 0;

    always @(posedge clk) if (rst_n && sr_write_ok_o) ok_count++;

    // monitor: compare against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (status_o !== e.stat || blk_lock_o !== e.stat[3:2]) begin
                    n_fail++;
                    $display("FAIL %s status=%h blk=%h expected status=%h blk=%h",
                             e.tag, status_o, blk_lock_o, e.stat, e.stat[3:2]);
                end
                n_checks++;
                if (ok_count != e.oks) begin
                    n_fail++;
                    $display("FAIL %s ok_count=%0d expected %0d", e.tag, ok_count, e.oks);
                end
            end
        end
    end

    task automatic expect_now(input logic [7:0] s, input int oks, input string tag);
        exp_t e;
        @(negedge clk); #1;
        e.stat = s; e.oks = oks; e.tag = tag;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wren();
        @(negedge clk); wren_pulse_i = 1'b1;
        @(negedge clk); wren_pulse_i = 1'b0;
    endtask

    task automatic do_wrsr(input logic [7:0] d);
        @(negedge clk); wrsr_pulse_i = 1'b1; wrsr_data_i = d;
        @(negedge clk); wrsr_pulse_i = 1'b0; wrsr_data_i = 8'h00;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); wp_pin_i = v;
        idle(5);
    endtask

    // strobe width check for R3
    int strobe_run = 0;
    int strobe_max = 0;
    always @(posedge clk) begin
        if (sr_write_ok_o) strobe_run++; else strobe_run = 0;
        if (strobe_run > strobe_max) strobe_max = strobe_run;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        expect_now(8'h00, 0, "R1 reset state");
        n_checks++;
        if (sr_write_ok_o !== 1'b0) begin
            n_fail++; $display("FAIL R1 ok=%b expected 0", sr_write_ok_o);
        end

        // R3: no enable latch, write rejected
        do_wrsr(8'h8C); idle(3);
        expect_now(8'h00, 0, "R3 write without enable");

        // R2 enable latch
        do_wren(); idle(1);
        expect_now(8'h02, 0, "R2 enable sets bit 1");

        // R8/R9: busy window shows old bits, data bits 1:0 discarded
        do_wrsr(8'h7F); idle(2);
        expect_now(8'h03, 1, "R9 busy, old bits visible");
        idle(N + 2);
        expect_now(8'h0C, 1, "R8 R10 R11 committed, latch cleared");

        // R4: pen 0, pin low ignored; this write sets pen while pin low
        set_pin(1'b0);
        do_wren();
        do_wrsr(8'h84); idle(N + 3);
        expect_now(8'h84, 2, "R4 pin low ignored when pen 0");

        // R6: locked now
        do_wren(); idle(1);
        do_wrsr(8'h00); idle(3);
        expect_now(8'h86, 2, "R6 locked, write rejected, latch kept");

        // R6 release by pin rising, R5 normal with pin high
        set_pin(1'b1);
        do_wrsr(8'h80); idle(N + 3);
        expect_now(8'h80, 3, "R5 R6 pin high after lock, write accepted");

        // R7: pin drops during a write in progress
        do_wren();
        do_wrsr(8'h88); idle(3);
        @(negedge clk); wp_pin_i = 1'b0;
        idle(N + 3);
        expect_now(8'h88, 4, "R7 in-progress write completes");
        do_wren();
        do_wrsr(8'h80); idle(3);
        expect_now(8'h8A, 4, "R7 later write rejected");

        // pin high, clear pen, then pin low with pen 0
        set_pin(1'b1);
        do_wrsr(8'h00); idle(N + 3);
        expect_now(8'h00, 5, "R5 clear protect-enable");
        set_pin(1'b0);
        do_wren();
        do_wrsr(8'h07); idle(N + 3);
        expect_now(8'h04, 6, "R4 R8 pin low, pen 0, bits 1:0 dropped");

        // R9/R10 array busy
        do_wren(); idle(1);
        expect_now(8'h06, 6, "R2 enable again");
        @(negedge clk); array_busy_i = 1'b1;
        idle(1);
        expect_now(8'h07, 6, "R9 array busy sets wip");
        do_wrsr(8'h80); idle(2);
        expect_now(8'h07, 6, "R3 write rejected while busy");
        @(negedge clk); array_busy_i = 1'b0;
        idle(2);
        expect_now(8'h04, 6, "R10 array write end clears latch");

        // R2 enable ignored while busy
        @(negedge clk); array_busy_i = 1'b1;
        do_wren(); idle(1);
        expect_now(8'h05, 6, "R2 enable ignored during wip");
        @(negedge clk); array_busy_i = 1'b0;
        idle(2);
        expect_now(8'h04, 6, "R2 latch still clear");

        n_checks++;
        if (strobe_max != 1) begin
            n_fail++; $display("FAIL R3 strobe width=%0d expected 1", strobe_max);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, sequence did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule